// File: doc/BRIEF.md
# Expanded Memory Page Mapper

This block puts a four-slot window into the upper memory area and points each slot at any page of a larger expanded memory. Software gives each slot a page number and an enable bit through a simple register write port. It also sets the 64 KB block of upper memory that holds the window. A 20-bit CPU address goes in, and one cycle later the block returns one of two results. If the address falls in an enabled slot, it returns the expanded-memory address with a hit flag. Otherwise it returns the CPU address unchanged with the hit flag low.

Changing a mapping only changes which expanded-memory address is produced. No data moves when a bank is switched. Each slot covers 16 KB. With four slots, a 64 KB part of expanded memory is visible at one time, taken from up to 64 pages of 16 KB.

Top module: `emm_page_mapper`

## Requirements
- R1: After reset every slot is disabled with page number 0, and the window base is block Dh (address D0000h). Every access then passes through with the hit flag low.
- R2: A write with `cfg_sel` from 0 to 3 loads that slot. `cfg_wdata[6]` is the enable bit and `cfg_wdata[5:0]` is the page number.
- R3: `out_valid` is high in the cycle after a cycle with `cpu_valid` high, and low in the cycle after a cycle with `cpu_valid` low. `out_hit` and `out_addr` belong to that same registered result.
- R4: An access counts as a hit when both of these hold. First, address bits [19:16] equal the window base. Second, the slot chosen by bits [15:14] is enabled. On a hit, `out_addr` is that slot's page number followed by CPU address bits [13:0].
- R5: An access outside the window, or to a disabled slot, returns `out_addr` equal to the CPU address with `out_hit` low.
- R6: A register write changes translation for requests sampled on the next clock edge. A request sampled on the same edge as the write still uses the old setting.
- R7: A write with `cfg_sel` = 4 sets the window base to the block number in `cfg_wdata`. The write is ignored unless the value is from Ah to Fh, which keeps the window inside upper memory.
- R8: Writes with `cfg_sel` from 5 to 7 change no slot and do not change the base.
- R9: `out_hit` is never high while `out_valid` is low.
- R10: Two slots may hold the same page number, and both then translate to the same expanded address.
- R11: The first and last byte of each slot translate correctly. The byte just below the window and the byte just above it pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0-3 slot, 4 window base, 5-7 unused |
| cfg_wdata | input | 7 | Write data: slot {enable, page[5:0]} or base block number |
| cpu_valid | input | 1 | CPU address valid |
| cpu_addr | input | 20 | CPU address |
| out_valid | output | 1 | Registered result valid |
| out_hit | output | 1 | Address was translated |
| out_addr | output | 20 | Expanded address on hit, CPU address otherwise |

## Verification
The hardest case to reach from the ports is a register write and a translation request landing on the same clock edge. In that case the old mapping must win, and the following request must see the new one. The bench drives both on one falling edge and then checks two back-to-back requests to the same address.

Two other cases are also hard to reach because nothing at the ports reads them back:
- Rejected base writes.
- Writes to the unused selects.

For these, the bench sends accesses at the old and new window positions and checks that the hit/miss pattern is unchanged.

// File: rtl/emm_pkg.sv
// Package: shared sizing for the expanded memory page mapper.
// Assumes a 20-bit real-mode address space with upper memory at A0000h.
package emm_pkg;
    localparam int ADDR_W     = 20;   // CPU address width
    localparam int OFS_W      = 14;   // 16 KB page offset
    localparam int SLOTS      = 4;    // slots in the page frame
    localparam int PAGE_W     = 6;    // up to 64 logical pages
    localparam int SEL_W      = 3;    // register select width
    localparam int BASE_RST   = 'hD;  // default frame block (D0000h)
    localparam int BASE_MIN   = 'hA;  // lowest block of upper memory
endpackage

// File: rtl/emm_map_regs.sv
// Module: mapping register file.
// Holds one {enable, page} register per slot plus the frame base block.
// Assumes the slot registers are selected by 0..SLOTS-1 and the base by SLOTS.
// A base write outside [BASE_MIN, 2**BASE_W-1] is dropped.
module emm_map_regs #(
    parameter int SLOTS    = emm_pkg::SLOTS,
    parameter int PAGE_W   = emm_pkg::PAGE_W,
    parameter int BASE_W   = 4,
    parameter int SEL_W    = emm_pkg::SEL_W,
    parameter int BASE_RST = emm_pkg::BASE_RST,
    parameter int BASE_MIN = emm_pkg::BASE_MIN,
    localparam int DATA_W  = PAGE_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [SEL_W-1:0]               cfg_sel,
    input  logic [DATA_W-1:0]              cfg_wdata,
    output logic [SLOTS-1:0]               slot_en,
    output logic [SLOTS-1:0][PAGE_W-1:0]   slot_page,
    output logic [BASE_W-1:0]              base_q
);
    localparam int BASE_MAX = (1 << BASE_W) - 1;

    logic base_ok;

    // Judge whether a base write names a block inside upper memory.
    always_comb begin
        base_ok = (int'(cfg_wdata) >= BASE_MIN) && (int'(cfg_wdata) <= BASE_MAX);
    end

    // One register per slot, loaded when its own select is written.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_en[s]   <= 1'b0;
                slot_page[s] <= '0;
            end else if (cfg_we && (cfg_sel == SEL_W'(s))) begin
                slot_en[s]   <= cfg_wdata[PAGE_W];
                slot_page[s] <= cfg_wdata[PAGE_W-1:0];
            end
        end
    end

    // Frame base register, updated only by an in-range write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= BASE_W'(BASE_RST);
        end else if (cfg_we && (cfg_sel == SEL_W'(SLOTS)) && base_ok) begin
            base_q <= cfg_wdata[BASE_W-1:0];
        end
    end
endmodule

// File: rtl/emm_slot_decode.sv
// Module: frame decode and address translation (combinational).
// Compares the top address bits with the frame base, picks the slot from the
// bits just above the page offset and builds {page, offset} on a hit.
// Assumes the frame size equals SLOTS pages and BASE_W covers the bits above it.
module emm_slot_decode #(
    parameter int ADDR_W  = emm_pkg::ADDR_W,
    parameter int OFS_W   = emm_pkg::OFS_W,
    parameter int SLOTS   = emm_pkg::SLOTS,
    parameter int PAGE_W  = emm_pkg::PAGE_W,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BASE_W = ADDR_W - OFS_W - SLOT_W,
    localparam int XW     = PAGE_W + OFS_W
) (
    input  logic [ADDR_W-1:0]              cpu_addr,
    input  logic [BASE_W-1:0]              base_q,
    input  logic [SLOTS-1:0]               slot_en,
    input  logic [SLOTS-1:0][PAGE_W-1:0]   slot_page,
    output logic                           hit,
    output logic [XW-1:0]                  xaddr
);
    logic              in_frame;
    logic [SLOT_W-1:0] slot_idx;
    logic [PAGE_W-1:0] page_sel;
    logic              en_sel;

    // Split the CPU address into frame tag and slot index.
    always_comb begin
        in_frame = (cpu_addr[ADDR_W-1 -: BASE_W] == base_q);
        slot_idx = cpu_addr[OFS_W +: SLOT_W];
    end

    // Select the addressed slot's enable and page.
    always_comb begin
        page_sel = '0;
        en_sel   = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot_idx == SLOT_W'(s)) begin
                page_sel = slot_page[s];
                en_sel   = slot_en[s];
            end
        end
    end

    // Form the translated or passed-through address.
    always_comb begin
        hit   = in_frame && en_sel;
        xaddr = hit ? {page_sel, cpu_addr[OFS_W-1:0]} : XW'(cpu_addr);
    end
endmodule

// File: rtl/emm_xlate_stage.sv
// Module: result register giving translation its single cycle of latency.
// The hit flag is forced low on idle cycles; the address holds its last value.
module emm_xlate_stage #(
    parameter int XW = emm_pkg::PAGE_W + emm_pkg::OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_hit,
    input  logic [XW-1:0] in_addr,
    output logic          out_valid,
    output logic          out_hit,
    output logic [XW-1:0] out_addr
);
    // Register valid and hit every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= in_valid && in_hit;
        end
    end

    // Capture the address only for a valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
        end else if (in_valid) begin
            out_addr <= in_addr;
        end
    end
endmodule

// File: rtl/emm_page_mapper.sv
// Module: top of the expanded memory page mapper.
// Ties the register file, the combinational decode and the output register.
// Assumes register writes and requests share one clock; a write is visible to
// requests sampled on the following edge.
module emm_page_mapper #(
    parameter int ADDR_W   = emm_pkg::ADDR_W,
    parameter int OFS_W    = emm_pkg::OFS_W,
    parameter int SLOTS    = emm_pkg::SLOTS,
    parameter int PAGE_W   = emm_pkg::PAGE_W,
    parameter int SEL_W    = emm_pkg::SEL_W,
    parameter int BASE_RST = emm_pkg::BASE_RST,
    parameter int BASE_MIN = emm_pkg::BASE_MIN,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int BASE_W  = ADDR_W - OFS_W - SLOT_W,
    localparam int DATA_W  = PAGE_W + 1,
    localparam int XW      = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [XW-1:0]     out_addr
);
    logic [SLOTS-1:0]             slot_en;
    logic [SLOTS-1:0][PAGE_W-1:0] slot_page;
    logic [BASE_W-1:0]            base_q;
    logic                         dec_hit;
    logic [XW-1:0]                dec_addr;

    emm_map_regs #(
        .SLOTS(SLOTS), .PAGE_W(PAGE_W), .BASE_W(BASE_W), .SEL_W(SEL_W),
        .BASE_RST(BASE_RST), .BASE_MIN(BASE_MIN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .slot_en(slot_en), .slot_page(slot_page),
        .base_q(base_q)
    );

    emm_slot_decode #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SLOTS(SLOTS), .PAGE_W(PAGE_W)
    ) u_dec (
        .cpu_addr(cpu_addr), .base_q(base_q), .slot_en(slot_en),
        .slot_page(slot_page), .hit(dec_hit), .xaddr(dec_addr)
    );

    emm_xlate_stage #(.XW(XW)) u_out (
        .clk(clk), .rst_n(rst_n), .in_valid(cpu_valid), .in_hit(dec_hit),
        .in_addr(dec_addr), .out_valid(out_valid), .out_hit(out_hit),
        .out_addr(out_addr)
    );
endmodule

// File: rtl/emm_page_mapper_chk.sv
// Module: property checker bound to the page mapper top.
module emm_page_mapper_chk #(
    parameter int ADDR_W   = 20,
    parameter int OFS_W    = 14,
    parameter int BASE_W   = 4,
    parameter int XW       = 20,
    parameter int BASE_MIN = 'hA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [BASE_W-1:0] base_q,
    input logic              out_valid,
    input logic              out_hit,
    input logic [XW-1:0]     out_addr
);
    // R9: a hit is only reported with a valid result
    a_r9_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_valid);

    // R3: result validity follows the request one cycle later
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |=> out_valid);
    a_r3_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |=> !out_valid);

    // R4: a hit keeps the page offset of the request
    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid ##1 out_hit) |-> out_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0]));

    // R4: a hit only comes from an address inside the frame
    a_r4_hit_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid ##1 out_hit) |-> $past(cpu_addr[ADDR_W-1 -: BASE_W]) == $past(base_q));

    // R5: a miss returns the request address unchanged
    a_r5_pass_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid ##1 (out_valid && !out_hit)) |-> out_addr == XW'($past(cpu_addr)));

    // R7: the frame base never leaves upper memory
    a_r7_base_in_uma: assert property (@(posedge clk) disable iff (!rst_n)
        int'(base_q) >= BASE_MIN);
endmodule

bind emm_page_mapper emm_page_mapper_chk #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .BASE_W(BASE_W), .XW(XW), .BASE_MIN(BASE_MIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .base_q(base_q), .out_valid(out_valid), .out_hit(out_hit), .out_addr(out_addr)
);

// File: tb/sim_emm_page_mapper.sv
module sim_emm_page_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [6:0]  cfg_wdata = '0;
    logic        cpu_valid = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic        out_valid;
    logic        out_hit;
    logic [19:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    emm_page_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_addr(out_addr)
    );

    typedef struct packed {
        logic [19:0] a;
        logic        h;
        logic [19:0] x;
    } vec_t;

    // R4/R5/R11 table; map: s0 en p5, s1 en p63, s2 off p9, s3 en p0, base D
    localparam vec_t VEC [10] = '{
        '{20'hD0000, 1'b1, 20'h14000},
        '{20'hD3FFF, 1'b1, 20'h17FFF},
        '{20'hD4000, 1'b1, 20'hFC000},
        '{20'hD7ABC, 1'b1, 20'hFFABC},
        '{20'hD8123, 1'b0, 20'hD8123},
        '{20'hDC010, 1'b1, 20'h00010},
        '{20'hDFFFF, 1'b1, 20'h03FFF},
        '{20'hCFFFF, 1'b0, 20'hCFFFF},
        '{20'hE0000, 1'b0, 20'hE0000},
        '{20'h00400, 1'b0, 20'h00400}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [6:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xl(input string req, input logic [19:0] a, input logic h, input logic [19:0] x);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a;
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " hit"}, 32'(out_hit), 32'(h));
        chk({req, " addr"}, 32'(out_addr), 32'(x));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1/R9 reset state: no result, no hit
        chk("R1 reset valid", 32'(out_valid), 32'd0);
        chk("R9 reset hit", 32'(out_hit), 32'd0);
        // R1: all slots disabled, base D
        xl("R1 reset D0000", 20'hD0000, 1'b0, 20'hD0000);
        xl("R1 reset DC000", 20'hDC000, 1'b0, 20'hDC000);

        // R2 program slots
        wr(3'd0, 7'h45);
        wr(3'd1, 7'h7F);
        wr(3'd2, 7'h09);
        wr(3'd3, 7'h40);
        for (int i = 0; i < 10; i++)
            xl("R4 R5 R11 table", VEC[i].a, VEC[i].h, VEC[i].x);

        // R3/R9 idle cycle produces no result
        @(negedge clk);
        chk("R3 idle valid", 32'(out_valid), 32'd0);
        chk("R9 idle hit", 32'(out_hit), 32'd0);

        // R7 move base to E, then reject block 5
        wr(3'd4, 7'h0E);
        xl("R7 base E hit", 20'hE0000, 1'b1, 20'h14000);
        xl("R7 old D miss", 20'hD0000, 1'b0, 20'hD0000);
        wr(3'd4, 7'h05);
        xl("R7 low base ignored", 20'hE0004, 1'b1, 20'h14004);
        xl("R7 low base ignored 5", 20'h50000, 1'b0, 20'h50000);
        wr(3'd4, 7'h1D);
        xl("R7 wide base ignored", 20'hE0004, 1'b1, 20'h14004);
        wr(3'd4, 7'h0D);
        xl("R7 base back D", 20'hD0008, 1'b1, 20'h14008);

        // R8 unused selects touch nothing
        wr(3'd5, 7'h41);
        wr(3'd6, 7'h0A);
        wr(3'd7, 7'h00);
        xl("R8 slot1 kept", 20'hD4000, 1'b1, 20'hFC000);
        xl("R8 slot2 kept", 20'hD8000, 1'b0, 20'hD8000);
        xl("R8 slot3 kept", 20'hDC000, 1'b1, 20'h00000);
        xl("R8 base kept", 20'hD0000, 1'b1, 20'h14000);

        // R6 write and request on the same edge: old mapping, then new
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 7'h42;
        cpu_valid = 1'b1; cpu_addr = 20'hD0020;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R6 same edge old map", 32'(out_addr), 32'h14020);
        chk("R6 same edge hit", 32'(out_hit), 32'd1);
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        chk("R6 next edge new map", 32'(out_addr), 32'h08020);

        // R10 two slots on one page
        wr(3'd3, 7'h42);
        xl("R10 alias slot3", 20'hDC123, 1'b1, 20'h08123);
        xl("R10 alias slot0", 20'hD0123, 1'b1, 20'h08123);

        // R2 disable slot0 keeping its page
        wr(3'd0, 7'h02);
        xl("R2 slot0 disabled", 20'hD0123, 1'b0, 20'hD0123);

        // R1 reset again clears mapping
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        xl("R1 re-reset slot1", 20'hD4000, 1'b0, 20'hD4000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule